// File: doc/BRIEF.md
# Split RAM Pointer Register Unit

This unit holds the data-memory pointer of a small 4-bit controller. The 7-bit pointer has two fields. The upper 3 bits are the bank field and select a register row. The lower 4 bits are the digit field and select a nibble within that row. Each cycle in which `step` is high, the unit takes one decoded pointer instruction and updates the pointer. The instruction arrives as an opcode, a 2-bit row operand, a 4-bit digit operand and the accumulator value. The memory array itself lives outside the unit. It is addressed by `ptr`.

The digit field can step up or down as part of an exchange. When it wraps, the unit raises a one-instruction `skip` request for the sequencer. The bank field is never stepped. It is changed by XOR with the row operand, by a zero-extended load, or by a swap with the accumulator. A pointer load-immediate opens a run. Any load-immediate that follows it directly is ignored, so that a chain of loads behaves as one.

Two instructions write the accumulator: copy digit to accumulator, and swap bank with accumulator. For these the unit presents a write strobe and data in the same cycle.

Top module: `ram_ptr_unit`

## Requirements
- R1: While reset is asserted and after its release, `ptr` is 0, `skip` is 0 and no load-immediate run is open.
- R2: Opcode 1 (increment-exchange) sets digit to digit+1 mod 16 and bank to bank XOR r. `skip` is 1 after this step exactly when the old digit was 15.
- R3: Opcode 2 (decrement-exchange) sets digit to digit-1 mod 16 and bank to bank XOR r. `skip` is 1 after this step exactly when the old digit was 0.
- R4: Opcode 3 (row XOR) keeps the digit and sets bank to bank XOR r, with `skip` 0.
- R5: Opcode 4 (store-and-advance) sets digit to digit+1 mod 16, keeps the bank, and leaves `skip` 0, including when the digit wraps from 15.
- R6: Opcode 5 (short load-immediate) sets digit to (d_val+1) mod 16, so an encoded 15 loads 0. It sets bank to r zero-extended.
- R7: Opcode 6 (long load-immediate) sets digit to d_val and bank to r zero-extended.
- R8: An opcode 5 or 6 step that directly follows another opcode 5 or 6 step leaves `ptr` unchanged. Steps with `step` low in between do not break the run. The first step with any other opcode closes the run.
- R9: Opcode 7 copies `acc_in` into the digit. Opcode 8 drives `acc_we`=1 and `acc_wdata`=digit in the same cycle and leaves `ptr` unchanged.
- R10: Opcode 9 sets bank to `acc_in[2:0]` and drives `acc_we`=1 with `acc_wdata` = {0, old bank} in the same cycle.
- R11: With `step` low, `ptr` and `skip` keep their values and `acc_we` is 0.
- R12: `skip` reflects only the most recent step. Every step that does not wrap under opcode 1 or 2 leaves it 0.
- R13: Opcode 0 and opcodes 10 to 15 leave `ptr` unchanged and write nothing to the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step | input | 1 | Instruction strobe; opcode and operands are valid |
| op | input | 4 | Decoded pointer opcode |
| r_sel | input | 2 | Row operand r |
| d_val | input | 4 | Digit operand (encoded form for opcode 5) |
| acc_in | input | 4 | Current accumulator value |
| ptr | output | 7 | Pointer {bank, digit} |
| dig_out | output | 4 | Digit field for the output port |
| skip | output | 1 | Skip request from the last step |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 4 | Accumulator write data |

## Verification
The assertions take `op` and the operands to be known values whenever `step` is high. They also take `step` to stay low until the internal reset release has passed. A run check compares `ptr` across two steps in a row only when both steps were load-immediates on adjacent clocks. The stimulus drives every input from a defined value on the falling edge and holds `step` low through reset and the synchronizer delay. It mixes directed chains with random opcodes, including the unused codes and idle gaps inside load-immediate runs.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_INC_XR   = 4'd1,
    OP_DEC_XR   = 4'd2,
    OP_XR       = 4'd3,
    OP_STEP_UP  = 4'd4,
    OP_LDI_S    = 4'd5,
    OP_LDI_L    = 4'd6,
    OP_A2D      = 4'd7,
    OP_D2A      = 4'd8,
    OP_SWAP_A_R = 4'd9
  } ptr_op_e;

  function automatic logic is_ldi(ptr_op_e o);
    return (o == OP_LDI_S) || (o == OP_LDI_L);
  endfunction
endpackage

// File: rtl/ptr_digit.sv
module ptr_digit
  import ptr_pkg::*;
#(
  parameter int BD_W = 4
) (
  input  ptr_op_e          op,
  input  logic             hold,
  input  logic [BD_W-1:0]  ld_val,
  input  logic [BD_W-1:0]  acc,
  input  logic [BD_W-1:0]  cur,
  output logic [BD_W-1:0]  nxt,
  output logic             wrap
);
  localparam logic [BD_W-1:0] TOP_V = '1;
  localparam logic [BD_W-1:0] ONE_V = BD_W'(1);

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (!hold) begin
      unique case (op)
        OP_INC_XR: begin
          nxt  = cur + ONE_V;
          wrap = (cur == TOP_V);
        end
        OP_DEC_XR: begin
          nxt  = cur - ONE_V;
          wrap = (cur == '0);
        end
        OP_STEP_UP: nxt = cur + ONE_V;
        OP_LDI_S:   nxt = ld_val + ONE_V;
        OP_LDI_L:   nxt = ld_val;
        OP_A2D:     nxt = acc;
        default:    nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
  import ptr_pkg::*;
#(
  parameter int BR_W  = 3,
  parameter int R_W   = 2,
  parameter int ACC_W = 4
) (
  input  ptr_op_e          op,
  input  logic             hold,
  input  logic [R_W-1:0]   r,
  input  logic [ACC_W-1:0] acc,
  input  logic [BR_W-1:0]  cur,
  output logic [BR_W-1:0]  nxt
);
  logic [BR_W-1:0] r_ext;
  logic [BR_W-1:0] acc_lo;

  generate
    if (R_W >= BR_W) begin : g_r_trunc
      assign r_ext = r[BR_W-1:0];
    end else begin : g_r_zext
      assign r_ext = {{(BR_W-R_W){1'b0}}, r};
    end
    if (ACC_W >= BR_W) begin : g_a_trunc
      assign acc_lo = acc[BR_W-1:0];
    end else begin : g_a_zext
      assign acc_lo = {{(BR_W-ACC_W){1'b0}}, acc};
    end
  endgenerate

  always_comb begin
    nxt = cur;
    if (!hold) begin
      unique case (op)
        OP_INC_XR, OP_DEC_XR, OP_XR: nxt = cur ^ r_ext;
        OP_LDI_S, OP_LDI_L:          nxt = r_ext;
        OP_SWAP_A_R:                 nxt = acc_lo;
        default:                     nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/ptr_ldi_run.sv
module ptr_ldi_run
  import ptr_pkg::*;
(
  input  ptr_op_e op,
  input  logic    step,
  input  logic    run_q,
  output logic    run_d,
  output logic    suppress
);
  logic ldi;

  always_comb begin
    ldi      = is_ldi(op);
    suppress = run_q & ldi;
    run_d    = step ? ldi : run_q;
  end
endmodule

// File: rtl/ram_ptr_unit.sv
module ram_ptr_unit
  import ptr_pkg::*;
#(
  parameter int BR_W  = 3,
  parameter int BD_W  = 4,
  parameter int R_W   = 2,
  parameter int ACC_W = 4,
  localparam int PTR_W = BR_W + BD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [3:0]       op,
  input  logic [R_W-1:0]   r_sel,
  input  logic [BD_W-1:0]  d_val,
  input  logic [ACC_W-1:0] acc_in,
  output logic [PTR_W-1:0] ptr,
  output logic [BD_W-1:0]  dig_out,
  output logic             skip,
  output logic             acc_we,
  output logic [ACC_W-1:0] acc_wdata
);
  logic [1:0]      rst_sync;
  logic            rst_q_n;
  ptr_op_e         op_e;
  logic [BD_W-1:0] bd_q, bd_d, acc_dig;
  logic [BR_W-1:0] br_q, br_d;
  logic            skip_q, skip_d, run_q, run_d;
  logic            hold, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign op_e = ptr_op_e'(op);

  generate
    if (ACC_W >= BD_W) begin : g_acc_wide
      assign acc_dig = acc_in[BD_W-1:0];
    end else begin : g_acc_narrow
      assign acc_dig = {{(BD_W-ACC_W){1'b0}}, acc_in};
    end
  endgenerate

  ptr_ldi_run u_run (
    .op(op_e), .step(step), .run_q(run_q), .run_d(run_d), .suppress(hold)
  );

  ptr_digit #(.BD_W(BD_W)) u_dig (
    .op(op_e), .hold(hold), .ld_val(d_val), .acc(acc_dig),
    .cur(bd_q), .nxt(bd_d), .wrap(wrap)
  );

  ptr_bank #(.BR_W(BR_W), .R_W(R_W), .ACC_W(ACC_W)) u_bank (
    .op(op_e), .hold(hold), .r(r_sel), .acc(acc_in),
    .cur(br_q), .nxt(br_d)
  );

  assign skip_d = wrap;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bd_q   <= '0;
      br_q   <= '0;
      skip_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (step) begin
      bd_q   <= bd_d;
      br_q   <= br_d;
      skip_q <= skip_d;
      run_q  <= run_d;
    end
  end

  always_comb begin
    acc_we    = step && ((op_e == OP_D2A) || (op_e == OP_SWAP_A_R));
    acc_wdata = (op_e == OP_D2A) ? ACC_W'(bd_q) : ACC_W'(br_q);
  end

  assign ptr     = {br_q, bd_q};
  assign dig_out = bd_q;
  assign skip    = skip_q;
endmodule

// File: rtl/ram_ptr_unit_chk.sv
module ram_ptr_unit_chk #(
  parameter int BD_W  = 4,
  parameter int PTR_W = 7,
  parameter int ACC_W = 4
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             step,
  input logic [3:0]       op,
  input logic [PTR_W-1:0] ptr,
  input logic             skip,
  input logic             acc_we,
  input logic [ACC_W-1:0] acc_wdata
);
  logic [BD_W-1:0] dig;
  logic            ldi_now;
  assign dig     = ptr[BD_W-1:0];
  assign ldi_now = step && ((op == 4'd5) || (op == 4'd6));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_q_n |-> (ptr == '0) && !skip);                               // R1
  AST_INC_WRAP_SKIP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step && op == 4'd1 && dig == '1) |=> skip);                      // R2
  AST_DEC_WRAP_SKIP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step && op == 4'd2 && dig == '0) |=> skip);                      // R3
  AST_XR_DIGIT_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step && op == 4'd3) |=> (ptr[BD_W-1:0] == $past(dig)) && !skip);  // R4
  AST_ADVANCE_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step && op == 4'd4) |=> !skip);                                  // R5
  AST_LDI_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ldi_now && $past(ldi_now)) |=> $stable(ptr));                    // R8
  AST_D2A_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step && op == 4'd8) |-> acc_we && (acc_wdata == ACC_W'(dig)));    // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step |=> $stable(ptr) && $stable(skip));                         // R11
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step |-> !acc_we);                                               // R11
endmodule

bind ram_ptr_unit ram_ptr_unit_chk #(.BD_W(BD_W), .PTR_W(PTR_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .step(step), .op(op), .ptr(ptr),
  .skip(skip), .acc_we(acc_we), .acc_wdata(acc_wdata)
);

// File: tb/ram_ptr_unit_tb.sv
module ram_ptr_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic [3:0] op = 4'd0;
  logic [1:0] r_sel = 2'd0;
  logic [3:0] d_val = 4'd0;
  logic [3:0] acc_in = 4'd0;
  logic [6:0] ptr;
  logic [3:0] dig_out;
  logic       skip, acc_we;
  logic [3:0] acc_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_bd = 0, m_br = 0, m_skip = 0, m_run = 0;
  string last_tag = "R1";
  string skip_tag = "R1";

  always #4 clk = ~clk;

  ram_ptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .r_sel(r_sel),
    .d_val(d_val), .acc_in(acc_in), .ptr(ptr), .dig_out(dig_out),
    .skip(skip), .acc_we(acc_we), .acc_wdata(acc_wdata)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int o, bit s, bit suppressed);
    if (!s) return "R11";
    if (suppressed) return "R8";
    case (o)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7, 8: return "R9";
      9: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic check_state();
    chk(last_tag, int'(ptr), m_br * 16 + m_bd);
    chk(last_tag, int'(dig_out), m_bd);
    chk(skip_tag, int'(skip), m_skip);
  endtask

  task automatic do_op(bit s, int o, int r, int d, int a);
    int exp_we;
    bit ldi, sup;
    @(negedge clk);
    check_state();
    step = s; op = 4'(o); r_sel = 2'(r); d_val = 4'(d); acc_in = 4'(a);
    #1;
    exp_we = (s && (o == 8 || o == 9)) ? 1 : 0;
    chk(!s ? "R11" : (o == 8 ? "R9" : (o == 9 ? "R10" : "R13")), int'(acc_we), exp_we);
    if (exp_we == 1)
      chk(o == 8 ? "R9" : "R10", int'(acc_wdata), (o == 8) ? m_bd : m_br);
    @(posedge clk);
    ldi = (o == 5 || o == 6);
    sup = s && ldi && (m_run == 1);
    if (s) begin
      int w = 0;
      if (!sup) begin
        case (o)
          1: begin w = (m_bd == 15); m_bd = (m_bd + 1) % 16; m_br = m_br ^ r; end
          2: begin w = (m_bd == 0);  m_bd = (m_bd + 15) % 16; m_br = m_br ^ r; end
          3: m_br = m_br ^ r;
          4: m_bd = (m_bd + 1) % 16;
          5: begin m_bd = (d + 1) % 16; m_br = r; end
          6: begin m_bd = d; m_br = r; end
          7: m_bd = a;
          9: m_br = a % 8;
          default: ;
        endcase
      end
      m_skip = w;
      m_run = ldi;
      skip_tag = (o == 1) ? "R2" : ((o == 2) ? "R3" : "R12");
    end else begin
      skip_tag = "R11";
    end
    last_tag = tag_of(o, s, sup);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(ptr), 0);
    chk("R1", int'(skip), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", int'(ptr), 0);
    // R6: encoded 15 loads digit 0, row 2
    do_op(1, 5, 2, 15, 0);
    do_op(1, 0, 0, 0, 0);
    // R7 then R2 wrap from 15
    do_op(1, 6, 1, 15, 0);
    do_op(1, 1, 3, 0, 0);
    do_op(1, 1, 1, 0, 0);
    // R3 wrap below 0
    do_op(1, 6, 0, 0, 0);
    do_op(1, 2, 2, 0, 0);
    do_op(1, 2, 2, 0, 0);
    // R5 wraps without skip
    do_op(1, 6, 3, 15, 0);
    do_op(1, 4, 0, 0, 0);
    // R8 run with idle gap, closed by R4
    do_op(1, 6, 1, 5, 0);
    do_op(1, 5, 3, 9, 0);
    do_op(0, 6, 2, 2, 0);
    do_op(1, 6, 2, 2, 0);
    do_op(1, 3, 3, 0, 0);
    do_op(1, 6, 2, 7, 0);
    // R9, R10
    do_op(1, 7, 0, 0, 11);
    do_op(1, 8, 0, 0, 0);
    do_op(1, 9, 0, 0, 13);
    do_op(1, 9, 0, 0, 2);
    // R13 unused codes
    do_op(1, 12, 3, 9, 9);
    do_op(1, 15, 3, 9, 9);
    for (int i = 0; i < 4000; i++)
      do_op(($urandom % 4) != 0, $urandom % 16, $urandom % 4, $urandom % 16, $urandom % 16);
    do_op(0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule